// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block tracks the four-state invalidate coherence state (Modified, Exclusive, Shared, Invalid) of a small array of cache lines in a snooping cache on a shared bus. Each cycle it may accept one event from the local processor side: read, write or eviction. In the same cycle it may also accept one event observed on the bus: bus read, bus write or bus upgrade. Each event names the line it targets by index.

For every accepted event the block computes the line's next state and emits the required actions as one-cycle pulses, one cycle after the event. The local actions are issuing a bus read, bus write or bus upgrade, and writing a victim back. The snoop actions are answering shared or dirty, writing the line back, and flagging an illegal upgrade snoop. When a local read misses, the controller samples the sharers-present input in the same cycle to choose between Exclusive and Shared.

A combinational lookup port returns the state of any line, so that the surrounding cache can read it. Data storage, bus arbitration and memory are outside this block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid on the lookup port. States are encoded I=0, S=1, E=2, M=3.
- R2: A local read (loc_op=0) to an Invalid line pulses bus_rd. The line becomes Exclusive when sharers_present is 0 in that cycle, and Shared when it is 1.
- R3: A local write (loc_op=1) to an Invalid line pulses bus_wr, and the line becomes Modified.
- R4: A local write to a Shared line pulses bus_upg and moves the line to Modified. A local write to an Exclusive line moves it to Modified with no bus action.
- R5: A local eviction (loc_op=2) leaves the line Invalid from any state. loc_wb pulses only when the evicted line was Modified.
- R6: A bus read snoop (snp_op=0) to an S or E line pulses resp_shared, and an E line becomes S. To an M line it pulses resp_dirty and snp_wb, and the line becomes S.
- R7: A bus write snoop (snp_op=1) moves S and E lines to Invalid. To an M line it pulses resp_dirty and snp_wb, then the line becomes Invalid.
- R8: A bus upgrade snoop (snp_op=2) moves an S line to Invalid. If it hits an E or M line, proto_err pulses and the state is unchanged.
- R9: A local read to an S, E or M line, a local write to an M line, and any snoop to an Invalid line produce no action and no state change.
- R10: When a local and a snoop event hit the same line in one cycle, the snoop is applied first, and the local event acts on the state the snoop leaves.
- R11: Every action is a single-cycle pulse in the cycle after its event. Nothing pulses without a valid event. Op code 3 on either side is ignored, and at most one of bus_rd, bus_wr and bus_upg is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local event present |
| loc_op | input | 2 | Local event: 0 read, 1 write, 2 evict, 3 none |
| loc_idx | input | IDX_W | Line targeted by the local event |
| sharers_present | input | 1 | Another cache holds the line; sampled on a local read miss |
| snp_valid | input | 1 | Snooped bus event present |
| snp_op | input | 2 | Snoop: 0 bus read, 1 bus write, 2 bus upgrade, 3 none |
| snp_idx | input | IDX_W | Line targeted by the snoop |
| look_idx | input | IDX_W | Line to read on the lookup port |
| look_state | output | 2 | State of line look_idx |
| bus_rd | output | 1 | Issue bus read |
| bus_wr | output | 1 | Issue bus write (read for ownership) |
| bus_upg | output | 1 | Issue bus upgrade |
| loc_wb | output | 1 | Write back the evicted line |
| resp_shared | output | 1 | Snoop response: shared copy held |
| resp_dirty | output | 1 | Snoop response: dirty copy supplied |
| snp_wb | output | 1 | Write back the snooped dirty line |
| proto_err | output | 1 | Upgrade snoop hit an E or M line |

## Verification
The bench builds the controller with NUM_LINES=4. With so few lines, random local and snoop indices collide on the same line in about a quarter of the cycles, which exercises the snoop-first ordering of R10 often. It also drives every line through all four states many times over. Random op codes include the ignored code 3 and a fair share of upgrade snoops, so illegal upgrades against E and M lines come up without any special steering.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        LOC_RD  = 2'd0,
        LOC_WR  = 2'd1,
        LOC_EV  = 2'd2,
        LOC_NOP = 2'd3
    } loc_op_e;

    typedef enum logic [1:0] {
        SNP_RD  = 2'd0,
        SNP_WR  = 2'd1,
        SNP_UPG = 2'd2,
        SNP_NOP = 2'd3
    } snp_op_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic upg;
        logic wb;
    } loc_act_t;

    typedef struct packed {
        logic shared;
        logic dirty;
        logic wb;
        logic err;
    } snp_act_t;

    typedef struct packed {
        loc_act_t loc;
        snp_act_t snp;
    } act_t;

endpackage

// File: rtl/mesi_snoop_fsm.sv
module mesi_snoop_fsm
    import mesi_pkg::*;
(
    input  line_st_e cur,
    input  logic     hit,
    input  snp_op_e  op,
    output line_st_e nxt,
    output snp_act_t act
);
    always_comb begin
        nxt = cur;
        act = '0;
        if (hit) begin
            unique case (op)
                SNP_RD: begin
                    unique case (cur)
                        ST_S: act.shared = 1'b1;
                        ST_E: begin act.shared = 1'b1; nxt = ST_S; end
                        ST_M: begin act.dirty = 1'b1; act.wb = 1'b1; nxt = ST_S; end
                        default: ;
                    endcase
                end
                SNP_WR: begin
                    unique case (cur)
                        ST_S, ST_E: nxt = ST_I;
                        ST_M: begin act.dirty = 1'b1; act.wb = 1'b1; nxt = ST_I; end
                        default: ;
                    endcase
                end
                SNP_UPG: begin
                    unique case (cur)
                        ST_S: nxt = ST_I;
                        ST_E, ST_M: act.err = 1'b1;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_local_fsm.sv
module mesi_local_fsm
    import mesi_pkg::*;
(
    input  line_st_e cur,
    input  logic     hit,
    input  loc_op_e  op,
    input  logic     sharers,
    output line_st_e nxt,
    output loc_act_t act
);
    always_comb begin
        nxt = cur;
        act = '0;
        if (hit) begin
            unique case (op)
                LOC_RD: begin
                    if (cur == ST_I) begin
                        act.rd = 1'b1;
                        nxt    = sharers ? ST_S : ST_E;
                    end
                end
                LOC_WR: begin
                    unique case (cur)
                        ST_I: begin act.wr  = 1'b1; nxt = ST_M; end
                        ST_S: begin act.upg = 1'b1; nxt = ST_M; end
                        ST_E: nxt = ST_M;
                        default: ;
                    endcase
                end
                LOC_EV: begin
                    act.wb = (cur == ST_M);
                    nxt    = ST_I;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_valid,
    input  logic [1:0]       loc_op,
    input  logic [IDX_W-1:0] loc_idx,
    input  logic             sharers_present,
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [IDX_W-1:0] look_idx,
    output logic [1:0]       look_state,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic             bus_upg,
    output logic             loc_wb,
    output logic             resp_shared,
    output logic             resp_dirty,
    output logic             snp_wb,
    output logic             proto_err
);
    line_st_e state_q [NUM_LINES];
    line_st_e state_d [NUM_LINES];
    line_st_e mid_st  [NUM_LINES];
    snp_act_t snp_act [NUM_LINES];
    loc_act_t loc_act [NUM_LINES];
    act_t     act_q, act_d;

    // Per line: snoop first, then the local event on the snoop's result.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic snp_hit, loc_hit;
        assign snp_hit = snp_valid && (snp_idx == IDX_W'(g));
        assign loc_hit = loc_valid && (loc_idx == IDX_W'(g));

        mesi_snoop_fsm u_snp (
            .cur (state_q[g]),
            .hit (snp_hit),
            .op  (snp_op_e'(snp_op)),
            .nxt (mid_st[g]),
            .act (snp_act[g])
        );

        mesi_local_fsm u_loc (
            .cur     (mid_st[g]),
            .hit     (loc_hit),
            .op      (loc_op_e'(loc_op)),
            .sharers (sharers_present),
            .nxt     (state_d[g]),
            .act     (loc_act[g])
        );
    end

    always_comb begin
        act_d = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            act_d.loc = act_d.loc | loc_act[i];
            act_d.snp = act_d.snp | snp_act[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) state_q[i] <= ST_I;
            act_q <= '0;
        end else begin
            for (int i = 0; i < NUM_LINES; i++) state_q[i] <= state_d[i];
            act_q <= act_d;
        end
    end

    assign look_state  = state_q[look_idx];
    assign bus_rd      = act_q.loc.rd;
    assign bus_wr      = act_q.loc.wr;
    assign bus_upg     = act_q.loc.upg;
    assign loc_wb      = act_q.loc.wb;
    assign resp_shared = act_q.snp.shared;
    assign resp_dirty  = act_q.snp.dirty;
    assign snp_wb      = act_q.snp.wb;
    assign proto_err   = act_q.snp.err;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loc_valid,
    input logic [1:0] loc_op,
    input logic       snp_valid,
    input logic [1:0] snp_op,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       bus_upg,
    input logic       resp_shared,
    input logic       resp_dirty,
    input logic       snp_wb,
    input logic       proto_err
);
    assert_one_bus_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr, bus_upg}));

    assert_rd_from_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> $past(loc_valid && loc_op == 2'd0));

    assert_upg_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_upg |-> $past(loc_valid && loc_op == 2'd1));

    assert_dirty_has_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_dirty |-> snp_wb);

    assert_resp_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_shared && resp_dirty));

    assert_err_from_upg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(snp_valid && snp_op == 2'd2));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (.*);

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;
    localparam int NL = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          loc_valid = 1'b0, snp_valid = 1'b0, sharers_present = 1'b0;
    logic [1:0]    loc_op = 2'd3, snp_op = 2'd3;
    logic [IW-1:0] loc_idx = '0, snp_idx = '0, look_idx = '0;
    logic [1:0]    look_state;
    logic bus_rd, bus_wr, bus_upg, loc_wb, resp_shared, resp_dirty, snp_wb, proto_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [1:0] mdl [NL];

    always #10 clk = ~clk;

    mesi_line_ctrl #(.NUM_LINES(NL)) u_mesi_line_ctrl (.*);

    function automatic string req_of(bit lv, logic [1:0] lop, int li,
                                     bit sv, logic [1:0] sop, int si, logic [1:0] sst);
        if (lv && sv && lop != 3 && sop != 3 && li == si) return "R10";
        if (sv && sop != 3) begin
            if (sst == 0) return "R9";
            return (sop == 0) ? "R6" : (sop == 1) ? "R7" : "R8";
        end
        if (lv && lop != 3) begin
            if (lop == 2) return "R5";
            if (lop == 0) return (mdl[li] == 0) ? "R2" : "R9";
            return (mdl[li] == 0) ? "R3" : (mdl[li] == 3) ? "R9" : "R4";
        end
        return "R11";
    endfunction

    task automatic step(bit lv, logic [1:0] lop, int li, bit sv, logic [1:0] sop,
                        int si, bit shr);
        logic [7:0] exp, got;
        logic [1:0] st;
        string tag;
        tag = req_of(lv, lop, li, sv, sop, si, mdl[si]);
        exp = '0; // {rd,wr,upg,lwb,shared,dirty,swb,err}
        if (sv) begin
            st = mdl[si];
            case (sop)
                2'd0: if (st == 1) exp[3] = 1;
                      else if (st == 2) begin exp[3] = 1; mdl[si] = 1; end
                      else if (st == 3) begin exp[2] = 1; exp[1] = 1; mdl[si] = 1; end
                2'd1: if (st == 1 || st == 2) mdl[si] = 0;
                      else if (st == 3) begin exp[2] = 1; exp[1] = 1; mdl[si] = 0; end
                2'd2: if (st == 1) mdl[si] = 0;
                      else if (st != 0) exp[0] = 1;
                default: ;
            endcase
        end
        if (lv) begin
            st = mdl[li];
            case (lop)
                2'd0: if (st == 0) begin exp[7] = 1; mdl[li] = shr ? 2'd1 : 2'd2; end
                2'd1: if (st == 0) begin exp[6] = 1; mdl[li] = 3; end
                      else if (st == 1) begin exp[5] = 1; mdl[li] = 3; end
                      else if (st == 2) mdl[li] = 3;
                2'd2: begin exp[4] = (st == 3); mdl[li] = 0; end
                default: ;
            endcase
        end
        @(negedge clk);
        loc_valid = lv; loc_op = lop; loc_idx = IW'(li);
        snp_valid = sv; snp_op = sop; snp_idx = IW'(si);
        sharers_present = shr;
        @(posedge clk);
        #1;
        got = {bus_rd, bus_wr, bus_upg, loc_wb, resp_shared, resp_dirty, snp_wb, proto_err};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actions got %b exp %b", tag, got, exp);
        end
        for (int i = 0; i < NL; i++) begin
            look_idx = IW'(i);
            #1;
            checks++;
            if (look_state !== mdl[i]) begin
                errors++;
                $display("FAIL %s line %0d state got %0d exp %0d", tag, i, look_state, mdl[i]);
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired got running exp finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) mdl[i] = 0;
        void'($urandom(32'd5521));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < NL; i++) begin
            look_idx = IW'(i);
            #1;
            checks++;
            if (look_state !== 2'd0) begin
                errors++;
                $display("FAIL R1 line %0d got %0d exp 0", i, look_state);
            end
        end
        // Directed corner cases
        step(1, 0, 0, 0, 3, 0, 0); // R2 -> E
        step(1, 0, 1, 0, 3, 0, 1); // R2 -> S
        step(1, 1, 2, 0, 3, 0, 0); // R3 -> M
        step(1, 1, 1, 0, 3, 0, 0); // R4 S->M upg
        step(1, 1, 0, 0, 3, 0, 0); // R4 E->M silent
        step(1, 0, 0, 0, 3, 0, 0); // R9 read hit M
        step(1, 1, 0, 0, 3, 0, 0); // R9 write hit M
        step(0, 0, 0, 1, 0, 3, 0); // R9 snoop to I
        step(0, 0, 0, 1, 0, 0, 0); // R6 M -> S dirty
        step(0, 0, 0, 1, 2, 2, 0); // R8 upg on M -> err
        step(0, 0, 0, 1, 1, 2, 0); // R7 M -> I dirty
        step(1, 0, 3, 0, 3, 0, 0); // R2 -> E
        step(0, 0, 0, 1, 2, 3, 0); // R8 upg on E -> err
        step(0, 0, 0, 1, 0, 3, 0); // R6 E -> S shared
        step(0, 0, 0, 1, 2, 3, 0); // R8 S -> I
        step(1, 2, 1, 0, 3, 0, 0); // R5 evict M wb
        step(1, 2, 0, 0, 3, 0, 0); // R5 evict S no wb
        step(1, 3, 2, 1, 3, 2, 0); // R11 nop codes
        step(0, 1, 2, 0, 1, 2, 0); // R11 invalid events
        step(1, 1, 3, 0, 3, 0, 0); // R3
        step(1, 1, 3, 1, 0, 3, 0); // R10 M->S by snoop, then upgrade
        step(1, 0, 3, 1, 1, 3, 1); // R10 M->I by snoop, then read miss
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 4) != 0, 2'($urandom), int'($urandom % NL),
                 ($urandom % 3) != 0, 2'($urandom), int'($urandom % NL),
                 1'($urandom));
        end
        @(negedge clk);
        loc_valid = 0; snp_valid = 0;
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule